// File: doc/BRIEF.md
# UART Interrupt Arbiter with Receive Timeout

This block decides which interrupt a 16550-style UART presents to its host. The UART runs with its FIFOs permanently on. The arbiter watches five sources:

- receive line errors
- the receive FIFO fill level against a programmable trigger
- a receive character timeout
- the transmit holding register becoming empty
- modem status changes

From these it drives one interrupt line and an identification byte. The identification byte is valid whenever the host reads the identification register.

Line errors, transmit-empty and modem-change events are held in sticky flags. The host clears each flag through the register access that services it. The data-available condition follows the FIFO level directly. The timeout has its own counter, which advances once per character time while the receive FIFO holds data and no character enters or leaves it.

The block holds two host-writable fields. The interrupt enable nibble gates each source class. The two-bit trigger select picks the receive threshold. Serial shifting, baud generation and FIFO storage sit outside this block and feed it through level and strobe inputs.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset, `irq` is 0, `iir_data` reads 0x81, every enable bit is 0 and the receive trigger is 1 byte.
- R2: `iir_data` bit 7 always reads 1 and bits 6:4 always read 0. Bit 0 is 0 exactly when an enabled source is pending. Bits 3:1 then carry the identification code: 011 line status, 110 timeout, 010 data available, 001 transmit empty, 000 modem status. The resulting bytes are 0x86, 0x8C, 0x84, 0x82 and 0x80, and 0x81 means nothing is pending.
- R3: A `line_err` pulse sets the line status source. An `lsr_rd` strobe clears it. When both occur in the same cycle, the source stays set.
- R4: Data available is pending while `rx_level` is at or above the trigger. It drops as soon as the level falls below the trigger.
- R5: A write on `fcr_wr` loads the trigger from `wdata[7:6]`: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14.
- R6: A timeout becomes pending after TO_CHARS `char_tick` pulses with `rx_level` nonzero and neither `rx_push` nor `rbr_rd` asserted. Either strobe, or an empty FIFO, clears it and restarts the count.
- R7: A rising edge of `thr_empty` sets transmit-empty. It clears on `thr_wr`, on `thr_empty` low, or on `iir_rd` while it is the reported source. An `iir_rd` while another source is reported leaves it set. A clear in the same cycle as the rising edge wins.
- R8: A `modem_chg` pulse sets the modem status source and `msr_rd` clears it.
- R9: A write on `ier_wr` loads the enables from `wdata[3:0]`: bit 0 covers data available and timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status. A disabled source is neither reported nor raises `irq`, but its sticky flag is kept and appears once it is enabled.
- R10: `irq` equals the inverse of `iir_data` bit 0 as it stood one clock earlier.
- R11: When several enabled sources are pending, the report follows this order: line status first, then timeout, then data available, then transmit empty, then modem status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Write strobe for the interrupt enable nibble |
| fcr_wr | input | 1 | Write strobe for the FIFO control byte (trigger field) |
| wdata | input | 8 | Host write data |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe (a character is popped) |
| thr_wr | input | 1 | Transmit holding register write strobe |
| rx_level | input | LVL_W | Current receive FIFO fill count |
| rx_push | input | 1 | A character entered the receive FIFO |
| char_tick | input | 1 | One pulse per character time |
| line_err | input | 1 | Overrun, parity, framing or break event |
| thr_empty | input | 1 | Transmit holding register is empty |
| modem_chg | input | 1 | A modem status input changed |
| irq | output | 1 | Registered interrupt request |
| iir_data | output | 8 | Identification byte |

## Verification
There are three typical state faults, and each shows at the ports within a cycle or two:

- A sticky flag that fails to set or clear shows up in `iir_data` in the cycle after the offending strobe. One clock later it also shows on `irq`.
- A wrong trigger decode moves the level at which the identification byte changes from 0x81 to 0x84.
- A timeout counter that counts too far, or that is not restarted by a push or read, shifts the cycle in which 0x8C appears relative to the last `char_tick`.

The checks therefore sample the identification byte right after each strobe or tick. They also confirm priority by stacking sources and peeling them off one access at a time.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Identification codes placed in bits 3:1 of the identification byte.
  typedef enum logic [2:0] {
    ID_MS   = 3'b000,
    ID_THRE = 3'b001,
    ID_RDA  = 3'b010,
    ID_LS   = 3'b011,
    ID_TO   = 3'b110
  } irq_id_e;

  typedef struct packed {
    logic ls;
    logic to;
    logic rda;
    logic thre;
    logic ms;
  } irq_src_t;

  // Receive trigger depth for each select code.
  function automatic int trig_depth(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_depth = 1;
      2'b01:   trig_depth = 4;
      2'b10:   trig_depth = 8;
      default: trig_depth = 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
      end
    end else begin : g_clr_wins
      always_comb begin
        flag_d = flag_q;
        if (set_i) flag_d = 1'b1;
        if (clr_i) flag_d = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int TO_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nonempty_i,
  input  logic activity_i,
  input  logic tick_i,
  output logic to_o
);
  localparam int CW = $clog2(TO_CHARS + 1);
  localparam logic [CW-1:0] LAST = CW'(TO_CHARS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          to_q, to_d;

  always_comb begin
    cnt_d = cnt_q;
    to_d  = to_q;
    if (!nonempty_i || activity_i) begin
      cnt_d = '0;
      to_d  = 1'b0;
    end else if (tick_i && !to_q) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        to_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign to_o = to_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_src_t      req_i,
  output logic          pend_o,
  output logic [2:0]    id_o
);
  irq_id_e id;

  always_comb begin
    if (req_i.ls)        id = ID_LS;
    else if (req_i.to)   id = ID_TO;
    else if (req_i.rda)  id = ID_RDA;
    else if (req_i.thre) id = ID_THRE;
    else                 id = ID_MS;
  end

  assign pend_o = |req_i;
  assign id_o   = id;
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TO_CHARS   = 4,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic             fcr_wr,
  input  logic [7:0]       wdata,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             rbr_rd,
  input  logic             thr_wr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             char_tick,
  input  logic             line_err,
  input  logic             thr_empty,
  input  logic             modem_chg,
  output logic             irq,
  output logic [7:0]       iir_data
);
  localparam int NSTICKY = 3;
  // Index 0 line status, 1 transmit empty, 2 modem status; only transmit empty lets clear win.
  localparam logic [NSTICKY-1:0] SET_WINS_VEC = 3'b101;

  logic [3:0] ier_q, ier_d;
  logic [1:0] trig_q, trig_d;
  logic       thr_prev_q;
  logic       irq_q;

  logic [NSTICKY-1:0] st_set, st_clr, st_q;
  logic               rda_lvl, to_flag;
  logic [LVL_W-1:0]   trig_lvl;
  irq_src_t           req;
  logic               pend;
  logic [2:0]         id;
  logic               thre_reported;
  logic               unused_wdata;

  assign unused_wdata = ^wdata[5:4];

  // Host-writable fields with explicit write enables.
  always_comb begin
    ier_d  = ier_q;
    trig_d = trig_q;
    if (ier_wr) ier_d  = wdata[3:0];
    if (fcr_wr) trig_d = wdata[7:6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q      <= '0;
      trig_q     <= '0;
      thr_prev_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      ier_q      <= ier_d;
      trig_q     <= trig_d;
      thr_prev_q <= thr_empty;
      irq_q      <= pend;
    end
  end

  // Receive trigger comparison.
  assign trig_lvl = LVL_W'(trig_depth(trig_q));
  assign rda_lvl  = (rx_level >= trig_lvl);

  uart_irq_timeout #(.TO_CHARS(TO_CHARS)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .nonempty_i(rx_level != '0),
    .activity_i(rx_push | rbr_rd),
    .tick_i    (char_tick),
    .to_o      (to_flag)
  );

  assign thre_reported = pend && (id == ID_THRE);

  assign st_set = {modem_chg, thr_empty & ~thr_prev_q, line_err};
  assign st_clr = {msr_rd, thr_wr | ~thr_empty | (iir_rd & thre_reported), lsr_rd};

  genvar g;
  generate
    for (g = 0; g < NSTICKY; g++) begin : g_sticky
      uart_irq_sticky #(.SET_WINS(SET_WINS_VEC[g])) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (st_set[g]),
        .clr_i (st_clr[g]),
        .flag_o(st_q[g])
      );
    end
  endgenerate

  always_comb begin
    req.ls   = st_q[0] & ier_q[2];
    req.to   = to_flag & ier_q[0];
    req.rda  = rda_lvl & ier_q[0];
    req.thre = st_q[1] & ier_q[1];
    req.ms   = st_q[2] & ier_q[3];
  end

  uart_irq_prio u_prio (
    .req_i (req),
    .pend_o(pend),
    .id_o  (id)
  );

  assign iir_data = {1'b1, 3'b000, id, ~pend};
  assign irq      = irq_q;
endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_push,
  input logic             rbr_rd,
  input logic             line_err,
  input logic             lsr_rd,
  input logic             modem_chg,
  input logic             msr_rd,
  input logic             thr_wr,
  input logic [LVL_W-1:0] rx_level,
  input logic [7:0]       iir_data,
  input logic             irq
);
  assert_iir_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iir_data[7:4] == 4'h8);

  assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !$past(iir_data[0]));

  assert_ls_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !line_err) |=> (iir_data[3:0] != 4'h6));

  assert_ms_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !modem_chg) |=> (iir_data[3:0] != 4'h0));

  assert_thre_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (iir_data[3:0] != 4'h2));

  assert_rda_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_data[3:0] == 4'h4) |-> (rx_level != '0));

  assert_to_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_data[3:0] == 4'hC) |-> $past(!rx_push && !rbr_rd));
endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk #(.LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_push  (rx_push),
  .rbr_rd   (rbr_rd),
  .line_err (line_err),
  .lsr_rd   (lsr_rd),
  .modem_chg(modem_chg),
  .msr_rd   (msr_rd),
  .thr_wr   (thr_wr),
  .rx_level (rx_level),
  .iir_data (iir_data),
  .irq      (irq)
);

// File: tb/uart_irq_arbiter_test.sv
module uart_irq_arbiter_test;
  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 0, fcr_wr = 0, iir_rd = 0, lsr_rd = 0, msr_rd = 0;
  logic rbr_rd = 0, thr_wr = 0, rx_push = 0, char_tick = 0;
  logic line_err = 0, thr_empty = 0, modem_chg = 0;
  logic [7:0] wdata = '0;
  logic [LVL_W-1:0] rx_level = '0;
  logic irq;
  logic [7:0] iir_data;

  always #5 clk = ~clk;

  uart_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .fcr_wr(fcr_wr), .wdata(wdata),
    .iir_rd(iir_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .rbr_rd(rbr_rd),
    .thr_wr(thr_wr), .rx_level(rx_level), .rx_push(rx_push),
    .char_tick(char_tick), .line_err(line_err), .thr_empty(thr_empty),
    .modem_chg(modem_chg), .irq(irq), .iir_data(iir_data)
  );

  typedef struct {
    string      tag;
    logic [7:0] iir;
    int         irq;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Monitor: pops one expectation per cycle, 3 ns after the rising edge.
  always @(posedge clk) begin
    #3;
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      n_cmp++;
      if (iir_data !== cur.iir) begin
        n_bad++;
        $display("FAIL %s: iir_data got %02h expected %02h", cur.tag, iir_data, cur.iir);
      end else if (cur.irq >= 0 && irq !== cur.irq[0]) begin
        n_bad++;
        $display("FAIL %s: irq got %0b expected %0d", cur.tag, irq, cur.irq);
      end
    end
  end

  task automatic clear_strobes();
    ier_wr = 0; fcr_wr = 0; iir_rd = 0; lsr_rd = 0; msr_rd = 0;
    rbr_rd = 0; thr_wr = 0; rx_push = 0; char_tick = 0;
    line_err = 0; modem_chg = 0;
  endtask

  // Driver: queue the outputs expected after the coming edge, then advance.
  task automatic cycle(input string tag, input logic [7:0] iir, input int irqv);
    sb_q.push_back('{tag, iir, irqv});
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic hold(input string tag, input logic [7:0] iir);
    cycle(tag, iir, iir[0] ? 0 : 1);
  endtask

  task automatic idle_step();
    @(negedge clk);
    clear_strobes();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cycle("R1 R2 reset identification", 8'h81, 0);

    // Default trigger is one byte.
    rx_level = 1; ier_wr = 1; wdata = 8'h01;
    cycle("R1 default trigger 1", 8'h84, 0);
    hold("R10 irq follows pending", 8'h84);
    rx_level = 0;
    cycle("R4 empty no data", 8'h81, -1);
    ier_wr = 1; wdata = 8'h0F;
    cycle("R9 all enabled idle", 8'h81, 0);

    // Line status and modem status stacking.
    line_err = 1;
    cycle("R3 line status set", 8'h86, 0);
    hold("R10 irq one cycle later", 8'h86);
    modem_chg = 1;
    cycle("R11 line over modem", 8'h86, 1);
    lsr_rd = 1;
    cycle("R3 cleared, R11 modem next", 8'h80, 1);
    hold("R8 modem held", 8'h80);
    msr_rd = 1;
    cycle("R8 modem cleared", 8'h81, 1);
    hold("R10 irq drops", 8'h81);

    // Trigger selection.
    fcr_wr = 1; wdata = 8'h40; rx_level = 3; rx_push = 1;
    cycle("R5 sel01 level3", 8'h81, -1);
    rx_level = 4; rx_push = 1;
    cycle("R5 sel01 level4", 8'h84, -1);
    rx_level = 3; rbr_rd = 1;
    cycle("R4 below trigger clears", 8'h81, -1);
    fcr_wr = 1; wdata = 8'h80; rx_level = 7;
    cycle("R5 sel10 level7", 8'h81, -1);
    rx_level = 8;
    cycle("R5 sel10 level8", 8'h84, -1);
    fcr_wr = 1; wdata = 8'hC0; rx_level = 13;
    cycle("R5 sel11 level13", 8'h81, -1);
    rx_level = 14;
    cycle("R5 sel11 level14", 8'h84, -1);
    hold("R4 data held", 8'h84);
    fcr_wr = 1; wdata = 8'h00; rx_level = 1;
    cycle("R5 sel00 level1", 8'h84, -1);
    rx_level = 0;
    cycle("R4 empty", 8'h81, -1);

    // Character timeout.
    fcr_wr = 1; wdata = 8'h80; rx_level = 2; rx_push = 1;
    cycle("R6 below trigger", 8'h81, -1);
    for (int i = 0; i < 3; i++) begin
      char_tick = 1;
      cycle("R6 still counting", 8'h81, -1);
    end
    char_tick = 1;
    cycle("R6 timeout fired", 8'h8C, 0);
    hold("R6 timeout held", 8'h8C);
    rx_level = 1; rbr_rd = 1;
    cycle("R6 read clears", 8'h81, -1);
    for (int i = 0; i < 3; i++) begin
      char_tick = 1;
      idle_step();
    end
    char_tick = 1;
    cycle("R6 refired after read", 8'h8C, -1);
    rx_level = 2; rx_push = 1;
    cycle("R6 push clears", 8'h81, -1);
    for (int i = 0; i < 4; i++) begin
      char_tick = 1;
      idle_step();
    end
    hold("R6 refired after push", 8'h8C);
    rx_level = 0;
    cycle("R6 empty clears", 8'h81, -1);
    fcr_wr = 1; wdata = 8'h00; rx_level = 2; rx_push = 1;
    cycle("R4 data available", 8'h84, -1);
    for (int i = 0; i < 3; i++) begin
      char_tick = 1;
      idle_step();
    end
    char_tick = 1;
    cycle("R11 timeout over data", 8'h8C, -1);
    ier_wr = 1; wdata = 8'h0E;
    cycle("R9 receive class masked", 8'h81, -1);
    ier_wr = 1; wdata = 8'h0F; rx_level = 0;
    cycle("R9 reenabled empty", 8'h81, -1);

    // Transmit holding empty.
    thr_empty = 1;
    cycle("R7 rising edge sets", 8'h82, -1);
    hold("R7 held", 8'h82);
    iir_rd = 1;
    cycle("R7 iir read clears", 8'h81, 1);
    hold("R7 stays clear", 8'h81);
    thr_empty = 0;
    idle_step();
    thr_empty = 1;
    cycle("R7 set again", 8'h82, -1);
    thr_wr = 1; thr_empty = 0;
    cycle("R7 write clears", 8'h81, -1);
    thr_empty = 1;
    cycle("R7 set third", 8'h82, -1);
    line_err = 1;
    cycle("R11 line over transmit", 8'h86, -1);
    iir_rd = 1;
    cycle("R7 iir read while not reported", 8'h86, -1);
    lsr_rd = 1;
    cycle("R7 flag survived", 8'h82, -1);
    iir_rd = 1;
    cycle("R7 cleared by iir read", 8'h81, -1);

    // Enable masking.
    ier_wr = 1; wdata = 8'h00; modem_chg = 1;
    cycle("R9 modem masked", 8'h81, -1);
    hold("R9 irq stays low", 8'h81);
    ier_wr = 1; wdata = 8'h08;
    cycle("R9 modem unmasked", 8'h80, 0);
    hold("R9 irq raised", 8'h80);
    msr_rd = 1;
    cycle("R8 read clears", 8'h81, -1);
    ier_wr = 1; wdata = 8'h0B; line_err = 1;
    cycle("R9 line masked", 8'h81, -1);
    ier_wr = 1; wdata = 8'h0F;
    cycle("R9 line unmasked", 8'h86, -1);
    line_err = 1; lsr_rd = 1;
    cycle("R3 set wins over read", 8'h86, -1);
    lsr_rd = 1;
    cycle("R3 read clears", 8'h81, -1);

    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule